// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Timer

This block is the timing core of a master on an open-drain single-wire bus. The host hands it one command at a time: a bus reset, a single bit write, or a single bit read. The block then produces the exact low and release phases that command needs. It drives an active-low pull-down enable for the external bus driver and watches the bus level through a synchronizer. When the command ends, it pulses a completion strobe for one clock. The strobe carries the result: whether any device answered the reset, or the bit read back.

All durations are counted in microseconds. A prescaler divides the system clock by `CLKS_PER_US` to make the microsecond tick, and it restarts on every accepted command, so each phase lasts an exact number of clocks. Every phase length is a parameter. The defaults are as follows:
- Reset: the line is held low for 480 µs, then released for 480 µs. Presence is sampled 70 µs after the release.
- Read and write-one: the line is held low for 6 µs.
- Write-zero: the line is held low for 60 µs.
- Read sample: taken 13 µs into the slot.
- Bit slots: each lasts 70 µs, followed by 5 µs of recovery.

Byte sequencing, search, CRC checking and speed modes belong to the layers above this block.

Top module: `owb_master`

## Requirements
- R1: After reset the pull-down enable is inactive (`bus_pd_n` = 1), `cmd_ready` = 1 and `done` = 0.
- R2: A command is accepted on a clock edge where `cmd_valid` = 1, `cmd_ready` = 1 and `cmd_op` is not 2'b00. A reset command (`cmd_op` = 2'b01) drives `bus_pd_n` low for exactly T_RST_LOW·CLKS_PER_US clocks, starting with the accepting edge.
- R3: On a reset command, `presence` is set to the inverse of the bus level sampled T_PRES_SAMPLE µs after release. `presence` is valid when `done` pulses and keeps its value until the next reset command completes.
- R4: A reset command finishes, with `done` high, exactly (T_RST_LOW+T_RST_HIGH)·CLKS_PER_US clocks after its accepting edge.
- R5: A write command (`cmd_op` = 2'b10) holds the line low for T_LOW_ONE µs when `cmd_wbit` = 1, and for T_LOW_ZERO µs when `cmd_wbit` = 0.
- R6: A read command (`cmd_op` = 2'b11) holds the line low for T_LOW_ONE µs. `rd_bit` returns the bus level sampled T_READ_SAMPLE µs after the slot start. That sample is the level two clocks before the sampling edge, because the bus goes through a two-flop synchronizer.
- R7: Every bit slot ends with `done` high exactly (T_SLOT+T_REC)·CLKS_PER_US clocks after acceptance. `done` is high for a single clock, with the line released and `cmd_ready` high.
- R8: While a command runs, `cmd_ready` is 0 and a presented command has no effect on the line timing or on completion.
- R9: `cmd_op` = 2'b00 is never accepted. The line stays released and no `done` occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 none, 01 bus reset, 10 write bit, 11 read bit |
| cmd_wbit | input | 1 | Bit value for a write command |
| cmd_ready | output | 1 | High when idle and able to accept a command |
| done | output | 1 | One-clock completion strobe |
| rd_bit | output | 1 | Last bit read from the bus |
| presence | output | 1 | A device answered the last bus reset |
| bus_in | input | 1 | Raw bus level (asynchronous) |
| bus_pd_n | output | 1 | Active-low pull-down enable for the bus driver |

## Verification
The hardest situation to reach is the sampling instant itself. Presence and the read bit are captured at one clock edge. That edge lies behind a prescaler and a two-flop synchronizer, so the observed level comes from two clocks earlier. The bench acts as the bus device. At each clock it decides whether to hold the line low, using pulse windows placed around the sampling point. The sweep covers several windows that land on the sample, windows that end just before it, and windows that start after it. The expected flag follows arithmetically from whether the window covers the clock two edges ahead of the sampling edge. A second command is also injected while a write-zero slot is running, to show that the line timing and completion are unchanged.

// File: rtl/owb_pkg.sv
package owb_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_RESET = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } owb_op_e;

endpackage

// File: rtl/owb_sync.sv
// Multi-stage synchronizer for the raw bus level; resets to the idle-high level.
module owb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/owb_prescaler.sv
// Microsecond tick generator; cleared at command start, counts only while running.
module owb_prescaler #(
    parameter int CLKS_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic             wrap;

    always_comb begin
        wrap  = run_i && (pre_q == PRE_LAST);
        pre_d = pre_q;
        if (clear_i)   pre_d = '0;
        else if (wrap) pre_d = '0;
        else if (run_i) pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick_o = wrap && !clear_i;
endmodule

// File: rtl/owb_profile.sv
// Maps the running command onto its phase boundaries in microseconds.
module owb_profile
    import owb_pkg::*;
#(
    parameter int US_W          = 10,
    parameter int T_RST_LOW     = 480,
    parameter int T_RST_HIGH    = 480,
    parameter int T_PRES_SAMPLE = 70,
    parameter int T_LOW_ONE     = 6,
    parameter int T_LOW_ZERO    = 60,
    parameter int T_READ_SAMPLE = 13,
    parameter int T_SLOT        = 70,
    parameter int T_REC         = 5
) (
    input  owb_op_e          op_i,
    input  logic             wbit_i,
    output logic [US_W-1:0]  low_us_o,
    output logic [US_W-1:0]  sample_us_o,
    output logic [US_W-1:0]  end_us_o,
    output logic             sample_en_o
);
    localparam logic [US_W-1:0] RST_LOW  = US_W'(T_RST_LOW);
    localparam logic [US_W-1:0] RST_SAMP = US_W'(T_RST_LOW + T_PRES_SAMPLE);
    localparam logic [US_W-1:0] RST_END  = US_W'(T_RST_LOW + T_RST_HIGH);
    localparam logic [US_W-1:0] BIT_ONE  = US_W'(T_LOW_ONE);
    localparam logic [US_W-1:0] BIT_ZERO = US_W'(T_LOW_ZERO);
    localparam logic [US_W-1:0] BIT_SAMP = US_W'(T_READ_SAMPLE);
    localparam logic [US_W-1:0] BIT_END  = US_W'(T_SLOT + T_REC);

    always_comb begin
        low_us_o    = BIT_ONE;
        sample_us_o = BIT_SAMP;
        end_us_o    = BIT_END;
        sample_en_o = 1'b0;
        unique case (op_i)
            OP_RESET: begin
                low_us_o    = RST_LOW;
                sample_us_o = RST_SAMP;
                end_us_o    = RST_END;
                sample_en_o = 1'b1;
            end
            OP_WRITE: begin
                low_us_o    = wbit_i ? BIT_ONE : BIT_ZERO;
            end
            OP_READ: begin
                sample_en_o = 1'b1;
            end
            default: begin
                sample_en_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/owb_engine.sv
// Slot sequencer: tracks elapsed microseconds, drives the pull, samples, completes.
module owb_engine
    import owb_pkg::*;
#(
    parameter int US_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  owb_op_e         start_op_i,
    input  logic            start_wbit_i,
    input  logic            tick_i,
    input  logic            bus_s_i,
    input  logic [US_W-1:0] low_us_i,
    input  logic [US_W-1:0] sample_us_i,
    input  logic [US_W-1:0] end_us_i,
    input  logic            sample_en_i,
    output owb_op_e         op_o,
    output logic            wbit_o,
    output logic            busy_o,
    output logic            pull_o,
    output logic            done_o,
    output logic            rd_bit_o,
    output logic            presence_o
);
    typedef struct packed {
        logic            busy;
        logic            pull;
        logic            done;
        owb_op_e         op;
        logic            wbit;
        logic [US_W-1:0] elapsed;
        logic            rd_bit;
        logic            presence;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic [US_W-1:0] elapsed_n;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        elapsed_n = st_q.elapsed + 1'b1;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy    = 1'b1;
                st_d.pull    = 1'b1;
                st_d.op      = start_op_i;
                st_d.wbit    = start_wbit_i;
                st_d.elapsed = '0;
            end
        end else if (tick_i) begin
            st_d.elapsed = elapsed_n;
            st_d.pull    = (elapsed_n < low_us_i);
            if (sample_en_i && (elapsed_n == sample_us_i)) begin
                if (st_q.op == OP_RESET) st_d.presence = !bus_s_i;
                else                     st_d.rd_bit   = bus_s_i;
            end
            if (elapsed_n == end_us_i) begin
                st_d.busy = 1'b0;
                st_d.pull = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.op       <= OP_IDLE;
            st_q.rd_bit   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_o       = st_q.op;
    assign wbit_o     = st_q.wbit;
    assign busy_o     = st_q.busy;
    assign pull_o     = st_q.pull;
    assign done_o     = st_q.done;
    assign rd_bit_o   = st_q.rd_bit;
    assign presence_o = st_q.presence;
endmodule

// File: rtl/owb_master.sv
module owb_master
    import owb_pkg::*;
#(
    parameter int CLKS_PER_US   = 50,
    parameter int SYNC_STAGES   = 2,
    parameter int T_RST_LOW     = 480,
    parameter int T_RST_HIGH    = 480,
    parameter int T_PRES_SAMPLE = 70,
    parameter int T_LOW_ONE     = 6,
    parameter int T_LOW_ZERO    = 60,
    parameter int T_READ_SAMPLE = 13,
    parameter int T_SLOT        = 70,
    parameter int T_REC         = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_wbit,
    output logic       cmd_ready,
    output logic       done,
    output logic       rd_bit,
    output logic       presence,
    input  logic       bus_in,
    output logic       bus_pd_n
);
    localparam int RST_TOTAL = T_RST_LOW + T_RST_HIGH;
    localparam int BIT_TOTAL = T_SLOT + T_REC;
    localparam int MAX_US    = (RST_TOTAL > BIT_TOTAL) ? RST_TOTAL : BIT_TOTAL;
    localparam int US_W      = $clog2(MAX_US + 1);

    logic            bus_s;
    logic            tick;
    logic            busy;
    logic            pull;
    logic            start;
    owb_op_e         op_run;
    logic            wbit_run;
    logic [US_W-1:0] low_us, sample_us, end_us;
    logic            sample_en;

    assign start = cmd_valid && !busy && (owb_op_e'(cmd_op) != OP_IDLE);

    owb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_in),
        .q_o   (bus_s)
    );

    owb_prescaler #(.CLKS_PER_US(CLKS_PER_US)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start),
        .run_i   (busy),
        .tick_o  (tick)
    );

    owb_profile #(
        .US_W(US_W), .T_RST_LOW(T_RST_LOW), .T_RST_HIGH(T_RST_HIGH),
        .T_PRES_SAMPLE(T_PRES_SAMPLE), .T_LOW_ONE(T_LOW_ONE),
        .T_LOW_ZERO(T_LOW_ZERO), .T_READ_SAMPLE(T_READ_SAMPLE),
        .T_SLOT(T_SLOT), .T_REC(T_REC)
    ) u_prof (
        .op_i        (op_run),
        .wbit_i      (wbit_run),
        .low_us_o    (low_us),
        .sample_us_o (sample_us),
        .end_us_o    (end_us),
        .sample_en_o (sample_en)
    );

    owb_engine #(.US_W(US_W)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .start_op_i   (owb_op_e'(cmd_op)),
        .start_wbit_i (cmd_wbit),
        .tick_i       (tick),
        .bus_s_i      (bus_s),
        .low_us_i     (low_us),
        .sample_us_i  (sample_us),
        .end_us_i     (end_us),
        .sample_en_i  (sample_en),
        .op_o         (op_run),
        .wbit_o       (wbit_run),
        .busy_o       (busy),
        .pull_o       (pull),
        .done_o       (done),
        .rd_bit_o     (rd_bit),
        .presence_o   (presence)
    );

    assign cmd_ready = !busy;
    assign bus_pd_n  = !pull;
endmodule

// File: rtl/owb_master_chk.sv
module owb_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       cmd_ready,
    input logic       done,
    input logic       bus_pd_n
);
    logic accept;
    assign accept = cmd_valid && cmd_ready && (cmd_op != 2'b00);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> bus_pd_n); // R1
    AST_ACCEPT_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !bus_pd_n); // R2
    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !cmd_ready); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_pd_n && cmd_ready)); // R7
    AST_DONE_ENDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!cmd_ready)); // R7
    AST_NOOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && (!cmd_valid || cmd_op == 2'b00)) |=> cmd_ready); // R9
endmodule

bind owb_master owb_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .done      (done),
    .bus_pd_n  (bus_pd_n)
);

// File: tb/owb_master_tb.sv
module owb_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int C   = 2;
    localparam int RL  = 480, RH = 480, PS = 70;
    localparam int L1  = 6, L0 = 60, RS = 13, SL = 70, RC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic cmd_wbit = 1'b0;
    logic cmd_ready, done, rd_bit, presence, bus_pd_n;
    logic slave_low = 1'b0;
    wire  bus_in = bus_pd_n & ~slave_low;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    owb_master #(.CLKS_PER_US(C)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wbit(cmd_wbit), .cmd_ready(cmd_ready), .done(done),
        .rd_bit(rd_bit), .presence(presence), .bus_in(bus_in),
        .bus_pd_n(bus_pd_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one command with a device pulse window [s_start, s_start+s_len) in clocks
    // counted from the accepting edge; optionally presents a second command mid-slot.
    task automatic run_cmd(input logic [1:0] op, input logic wb, input int s_start,
                           input int s_len, input bit inject,
                           output int low_cnt, output int low_run, output int done_k,
                           output int done_cnt, output logic rb, output logic pr);
        bit released;
        low_cnt = 0; low_run = 0; done_k = -1; done_cnt = 0; rb = 1'b0; pr = 1'b0;
        released = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wbit = wb;
        @(posedge clk);
        for (int k = 0; k < (RL + RH) * C + 6; k++) begin
            @(negedge clk);
            if (k == 0) cmd_valid = 1'b0;
            if (!bus_pd_n) begin
                low_cnt++;
                if (!released) low_run++;
            end else begin
                released = 1'b1;
            end
            if (done) begin
                if (done_cnt == 0) begin
                    done_k = k; rb = rd_bit; pr = presence;
                end
                done_cnt++;
            end
            if (inject && k == 10) begin
                chk(cmd_ready == 1'b0, "R8 ready low while busy", int'(cmd_ready), 0);
                cmd_valid = 1'b1; cmd_op = 2'b11;
            end
            if (inject && k == 11) cmd_valid = 1'b0;
            slave_low = (s_len > 0) && (k >= s_start) && (k < s_start + s_len);
            if (done_cnt > 0 && k > done_k + 3) break;
        end
        slave_low = 1'b0;
    endtask

    function automatic bit covers(input int s_start, input int s_len, input int k);
        return (s_len > 0) && (k >= s_start) && (k < s_start + s_len);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "WATCHDOG run timed out", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int lc, lr, dk, dc;
        logic rb, pr;
        int waits[6] = '{15, 30, 60, 10, 75, 20};
        int lens[6]  = '{60, 120, 240, 50, 100, 40};
        int holds[5] = '{15, 30, 45, 10, 12};

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(bus_pd_n == 1'b1, "R1 line released after reset", int'(bus_pd_n), 1);
        chk(cmd_ready == 1'b1, "R1 ready after reset", int'(cmd_ready), 1);
        chk(done == 1'b0, "R1 done low after reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: no-op code held for a while
        cmd_valid = 1'b1; cmd_op = 2'b00;
        begin
            int lows = 0, dones = 0, notready = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!bus_pd_n) lows++;
                if (done) dones++;
                if (!cmd_ready) notready++;
            end
            chk(lows == 0, "R9 no-op leaves line released", lows, 0);
            chk(dones == 0 && notready == 0, "R9 no-op not accepted", dones + notready, 0);
        end
        cmd_valid = 1'b0;

        // R2 R3 R4: bus reset with a sweep of device presence windows
        for (int i = 0; i < 7; i++) begin
            int ss, sl, sk;
            bit expp;
            ss = (i < 6) ? (RL + waits[i]) * C : 0;
            sl = (i < 6) ? lens[i] * C : 0;
            sk = (RL + PS) * C - 3;
            expp = covers(ss, sl, sk);
            run_cmd(2'b01, 1'b0, ss, sl, 1'b0, lc, lr, dk, dc, rb, pr);
            chk(lr == RL * C && lc == RL * C, "R2 reset low length", lc, RL * C);
            chk(dk == (RL + RH) * C, "R4 reset completion cycle", dk, (RL + RH) * C);
            chk(dc == 1, "R7 single done pulse on reset", dc, 1);
            chk(pr == expp, "R3 presence flag", int'(pr), int'(expp));
        end

        // last reset had no device: presence 0. Run a reset with a device so R3 hold is visible.
        run_cmd(2'b01, 1'b0, (RL + 30) * C, 120 * C, 1'b0, lc, lr, dk, dc, rb, pr);
        chk(pr == 1'b1, "R3 presence seen", int'(pr), 1);

        // R5 R7: writes
        for (int b = 0; b < 2; b++) begin
            int expl;
            expl = (b == 1) ? L1 * C : L0 * C;
            run_cmd(2'b10, b[0], 0, 0, 1'b0, lc, lr, dk, dc, rb, pr);
            chk(lr == expl && lc == expl, "R5 write low length", lc, expl);
            chk(dk == (SL + RC) * C, "R7 write slot completion", dk, (SL + RC) * C);
            chk(dc == 1, "R7 write done single", dc, 1);
        end

        // R6: reads with device hold sweep (bit 0 if hold covers the sample)
        for (int i = 0; i < 6; i++) begin
            int ss, sl;
            bit expb;
            ss = C;
            sl = (i < 5) ? holds[i] * C : 0;
            expb = !covers(ss, sl, RS * C - 3);
            run_cmd(2'b11, 1'b0, ss, sl, 1'b0, lc, lr, dk, dc, rb, pr);
            chk(lr == L1 * C, "R6 read low length", lr, L1 * C);
            chk(rb == expb, "R6 read bit", int'(rb), int'(expb));
            chk(dk == (SL + RC) * C, "R7 read slot completion", dk, (SL + RC) * C);
        end
        // R3 presence held across bit slots
        @(negedge clk);
        chk(presence == 1'b1, "R3 presence held after bit slots", int'(presence), 1);

        // R8: command presented during a write-zero slot has no effect
        run_cmd(2'b10, 1'b0, 0, 0, 1'b1, lc, lr, dk, dc, rb, pr);
        chk(lr == L0 * C && lc == L0 * C, "R8 line timing unchanged", lc, L0 * C);
        chk(dk == (SL + RC) * C && dc == 1, "R8 completion unchanged", dk, (SL + RC) * C);
        repeat (4) @(negedge clk);
        chk(cmd_ready == 1'b1 && bus_pd_n == 1'b1, "R8 idle after slot", int'(cmd_ready), 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule